// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers a handful of interrupt sources that belong to each processor core and turns them into one interrupt request line per core. Each core has four generic-timer lines, a performance-monitor line and a mailbox summary line. One fast peripheral line is shared and goes to core 0 only. For every core, the sources that are allowed through are packed into a 32-bit pending word, and the core's request line is the OR of that word.

Software reaches the block through a small memory-mapped port. Writes are synchronous and reads are combinational. Each core has a timer-enable register that software updates with read-modify-write. Performance-monitor routing is changed through a pair of registers: one sets routing bits and the other clears them. Each core also has a read-only pending register. Pending bits follow their sources level for level, with nothing held. A core's interrupt handler reads its pending word and serves the lowest set bit first, so the bit position sets the priority.

The default configuration has four cores and an 8-bit byte address. The per-core banks hold at most eight cores.

Top module: `core_irq_router`

## Requirements
- R1: After reset every timer enable and every routing bit is zero, and all of them read as zero. With the mailbox and peripheral inputs low, every `core_irq` stays low even when all timer and performance lines are high.
- R2: A write to the timer-enable register of core c, at byte address 0x40 + 4·c, stores data bits 3:0 on the next clock edge. Bit 0 is the secure physical timer, bit 1 the non-secure physical timer, bit 2 the hypervisor timer and bit 3 the virtual timer. A read returns those four bits, and bits 31:4 read as zero.
- R3: A write to the routing-set register at 0x10 sets routing bit c for every data bit c that is one and leaves the other routing bits unchanged. A read of 0x10 or of 0x14 returns the routing mask in bits NCORES-1:0.
- R4: A write to the routing-clear register at 0x14 clears routing bit c for every data bit c that is one and leaves the other routing bits unchanged.
- R5: The pending word of core c, read at 0x60 + 4·c, is laid out as follows. Bits 3:0 hold `tmr_lines[4c+k]` AND enable bit k. Bit 4 holds `mbox_sum[c]`. Bit 8 holds `periph_line` for core 0 and zero for every other core. Bit 9 holds `perf_lines[c]` AND routing bit c. All other bits are zero.
- R6: `core_irq[c]` is the OR of the pending word of core c, in the same cycle and with no register in between.
- R7: Pending bits are not latched. When a source drops, its pending bit and the request line it drove fall without waiting for a clock edge.
- R8: A write to a pending register, to an unmapped address or to a misaligned address changes no enable or routing state. A read of an unmapped or misaligned address returns zero.
- R9: A write to the timer-enable register of one core leaves the timer enables of every other core unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_lines | input | 4·NCORES | Timer lines, four per core, core c at [4c+3:4c] |
| mbox_sum | input | NCORES | Mailbox summary line per core |
| perf_lines | input | NCORES | Performance-monitor line per core |
| periph_line | input | 1 | Shared fast peripheral line, routed to core 0 |
| core_irq | output | NCORES | Interrupt request per core |

## Verification
The assertions sample the combinational pending words and request lines on the rising clock edge. They therefore assume that source lines and bus signals are settled and free of X at that edge whenever reset is released. The bench changes every input only on the falling edge and holds reset low from time zero, so each sampled value is stable. The routing assertions also assume at most one bus write per cycle, carried by a single strobe. The bench issues writes one at a time, each lasting exactly one clock period.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  localparam int DATA_W     = 32;
  localparam int TMR_LINES  = 4;
  localparam int BIT_MBOX   = 4;
  localparam int BIT_PERIPH = 8;
  localparam int BIT_PERF   = 9;

  // byte offsets of the register banks
  localparam int OFS_ROUTE_SET = 'h10;
  localparam int OFS_ROUTE_CLR = 'h14;
  localparam int OFS_TMR_BASE  = 'h40;
  localparam int OFS_PEND_BASE = 'h60;

  typedef logic [TMR_LINES-1:0] tmr_en_t;
  typedef logic [DATA_W-1:0]    word_t;

  // pending word of one core from its source levels and gates
  function automatic word_t assemble_pending(tmr_en_t lines, tmr_en_t en,
                                             logic mbox, logic periph,
                                             logic perf, logic perf_route);
    word_t w;
    w = '0;
    w[TMR_LINES-1:0] = lines & en;
    w[BIT_MBOX]      = mbox;
    w[BIT_PERIPH]    = periph;
    w[BIT_PERF]      = perf & perf_route;
    return w;
  endfunction

  // routing mask after a set and a clear mask are applied
  function automatic word_t route_next(word_t cur, word_t set_m, word_t clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/cirq_addr_dec.sv
module cirq_addr_dec
  import cirq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(NCORES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_tmr,
  output logic              hit_pend,
  output logic              hit_set,
  output logic              hit_clr,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] TMR_A  = ADDR_W'(OFS_TMR_BASE);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFS_PEND_BASE);
  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(OFS_ROUTE_SET);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(OFS_ROUTE_CLR);
  localparam logic [ADDR_W-3:0] SLOTS  = (ADDR_W-2)'(NCORES);

  function automatic logic in_bank(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = a - base;
    return (a >= base) && (d[1:0] == 2'b00) && (d[ADDR_W-1:2] < SLOTS);
  endfunction

  assign hit_tmr  = in_bank(addr, TMR_A);
  assign hit_pend = in_bank(addr, PEND_A);
  assign hit_set  = (addr == SET_A);
  assign hit_clr  = (addr == CLR_A);
  // both banks sit on 32-byte boundaries, so the slot is the word index
  assign idx      = addr[IDX_W+1:2];

endmodule

// File: rtl/cirq_cfg_regs.sv
module cirq_cfg_regs
  import cirq_pkg::*;
#(
  parameter int NCORES = 4,
  localparam int IDX_W = $clog2(NCORES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_tmr,
  input  logic                              wr_set,
  input  logic                              wr_clr,
  input  logic [IDX_W-1:0]                  idx,
  input  word_t                             wdata,
  output logic [NCORES-1:0][TMR_LINES-1:0]  tmr_en,
  output logic [NCORES-1:0]                 route
);

  logic [NCORES-1:0][TMR_LINES-1:0] en_q;
  logic [NCORES-1:0]                route_q;
  word_t                            route_nx;
  logic                             unused_route_hi;

  for (genvar c = 0; c < NCORES; c++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        en_q[c] <= '0;
      else if (wr_tmr && idx == IDX_W'(c))
        en_q[c] <= wdata[TMR_LINES-1:0];
    end
  end

  assign route_nx = route_next(word_t'(route_q),
                               wr_set ? wdata : '0,
                               wr_clr ? wdata : '0);
  assign unused_route_hi = ^route_nx[DATA_W-1:NCORES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      route_q <= '0;
    else if (wr_set || wr_clr)
      route_q <= route_nx[NCORES-1:0];
  end

  assign tmr_en = en_q;
  assign route  = route_q;

endmodule

// File: rtl/cirq_pend_gen.sv
module cirq_pend_gen
  import cirq_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic [NCORES*TMR_LINES-1:0]       tmr_lines,
  input  logic [NCORES-1:0][TMR_LINES-1:0]  tmr_en,
  input  logic [NCORES-1:0]                 mbox_sum,
  input  logic [NCORES-1:0]                 perf_lines,
  input  logic [NCORES-1:0]                 route,
  input  logic                              periph_line,
  output logic [NCORES-1:0][DATA_W-1:0]     pend
);

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    if (c == 0) begin : g_periph
      assign pend[c] = assemble_pending(tmr_lines[c*TMR_LINES +: TMR_LINES],
                                        tmr_en[c], mbox_sum[c], periph_line,
                                        perf_lines[c], route[c]);
    end else begin : g_plain
      assign pend[c] = assemble_pending(tmr_lines[c*TMR_LINES +: TMR_LINES],
                                        tmr_en[c], mbox_sum[c], 1'b0,
                                        perf_lines[c], route[c]);
    end
  end

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import cirq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NCORES*4-1:0]         tmr_lines,
  input  logic [NCORES-1:0]           mbox_sum,
  input  logic [NCORES-1:0]           perf_lines,
  input  logic                        periph_line,
  output logic [NCORES-1:0]           core_irq
);

  localparam int IDX_W = $clog2(NCORES);

  logic                             hit_tmr, hit_pend, hit_set, hit_clr;
  logic [IDX_W-1:0]                 idx;
  logic [NCORES-1:0][TMR_LINES-1:0] tmr_en;
  logic [NCORES-1:0]                route;
  logic [NCORES-1:0][DATA_W-1:0]    pend;

  cirq_addr_dec #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .hit_tmr  (hit_tmr),
    .hit_pend (hit_pend),
    .hit_set  (hit_set),
    .hit_clr  (hit_clr),
    .idx      (idx)
  );

  cirq_cfg_regs #(.NCORES(NCORES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_tmr (bus_we && hit_tmr),
    .wr_set (bus_we && hit_set),
    .wr_clr (bus_we && hit_clr),
    .idx    (idx),
    .wdata  (bus_wdata),
    .tmr_en (tmr_en),
    .route  (route)
  );

  cirq_pend_gen #(.NCORES(NCORES)) u_pend (
    .tmr_lines   (tmr_lines),
    .tmr_en      (tmr_en),
    .mbox_sum    (mbox_sum),
    .perf_lines  (perf_lines),
    .route       (route),
    .periph_line (periph_line),
    .pend        (pend)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_irq
    assign core_irq[c] = |pend[c];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_tmr)
      bus_rdata = word_t'(tmr_en[idx]);
    else if (hit_set || hit_clr)
      bus_rdata = word_t'(route);
    else if (hit_pend)
      bus_rdata = pend[idx];
  end

endmodule

// File: rtl/cirq_checker.sv
module cirq_checker
  import cirq_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_we,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [31:0]                      bus_wdata,
  input logic [NCORES-1:0][TMR_LINES-1:0] tmr_en,
  input logic [NCORES-1:0]                route,
  input logic [NCORES-1:0][DATA_W-1:0]    pend,
  input logic [NCORES-1:0]                core_irq,
  input logic [NCORES-1:0]                mbox_sum,
  input logic [NCORES-1:0]                perf_lines
);

  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(OFS_ROUTE_SET);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(OFS_ROUTE_CLR);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFS_PEND_BASE);
  localparam logic [ADDR_W-1:0] PEND_E = ADDR_W'(OFS_PEND_BASE + 4*NCORES);

  for (genvar c = 0; c < NCORES; c++) begin : g_chk
    // R6
    irq_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq[c] == (|pend[c]));
    // R3
    route_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == SET_A && bus_wdata[c]) |=> route[c]);
    // R4
    route_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CLR_A && bus_wdata[c]) |=> !route[c]);
    // R5
    perf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[c][BIT_PERF] == (perf_lines[c] && route[c]));
    // R5
    mbox_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[c][BIT_MBOX] == mbox_sum[c]);
    if (c > 0) begin : g_not0
      // R5
      periph_core0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[c][BIT_PERIPH]);
    end
  end

  // R8
  pend_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr >= PEND_A && bus_addr < PEND_E)
      |=> ($stable(route) && $stable(tmr_en)));

endmodule

bind core_irq_router cirq_checker #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tmr_en     (tmr_en),
  .route      (route),
  .pend       (pend),
  .core_irq   (core_irq),
  .mbox_sum   (mbox_sum),
  .perf_lines (perf_lines)
);

// File: tb/core_irq_router_bench.sv
module core_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_lines = '0;
  logic [3:0]  mbox_sum = '0;
  logic [3:0]  perf_lines = '0;
  logic        periph_line = 1'b0;
  logic [3:0]  core_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  core_irq_router u_core_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lines(tmr_lines),
    .mbox_sum(mbox_sum), .perf_lines(perf_lines), .periph_line(periph_line),
    .core_irq(core_irq)
  );

  localparam logic [7:0] A_SET = 8'h10, A_CLR = 8'h14, A_TMR = 8'h40, A_PEND = 8'h60;

  typedef struct packed {
    logic [1:0]  core;
    logic [3:0]  en;
    logic [3:0]  route;
    logic [15:0] tl;
    logic [3:0]  mb;
    logic [3:0]  pf;
    logic        pp;
    logic [31:0] exp;
  } vec_t;

  // expected words laid out per R5
  localparam vec_t VECS [6] = '{
    '{2'd0, 4'hF, 4'h0, 16'h000F, 4'h0, 4'h0, 1'b0, 32'h0000_000F},
    '{2'd1, 4'h5, 4'h2, 16'h00F0, 4'h2, 4'h2, 1'b1, 32'h0000_0215},
    '{2'd0, 4'h0, 4'h1, 16'hFFFF, 4'h0, 4'h1, 1'b1, 32'h0000_0300},
    '{2'd3, 4'h8, 4'h7, 16'hF000, 4'h8, 4'hF, 1'b1, 32'h0000_0018},
    '{2'd2, 4'h6, 4'h4, 16'h0200, 4'h0, 4'h4, 1'b0, 32'h0000_0202},
    '{2'd2, 4'hF, 4'h0, 16'h0000, 4'h0, 4'hF, 1'b1, 32'h0000_0000}
  };

  function automatic logic [7:0] slot(logic [7:0] base, int core);
    return 8'(int'(base) + 4*core);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state with gated sources all high
    tmr_lines = 16'hFFFF; perf_lines = 4'hF;
    #1 chk("R1 irq after reset", 32'(core_irq), 32'h0);
    for (int c = 0; c < 4; c++) begin
      bus_read(slot(A_TMR, c), rd);
      chk("R1 timer enable reset", rd, 32'h0);
    end
    bus_read(A_SET, rd);
    chk("R1 routing reset", rd, 32'h0);

    // R5 R6: vector table
    for (int i = 0; i < 6; i++) begin
      bus_write(slot(A_TMR, int'(VECS[i].core)), 32'(VECS[i].en));
      bus_write(A_CLR, 32'hF);
      bus_write(A_SET, 32'(VECS[i].route));
      @(negedge clk);
      tmr_lines = VECS[i].tl; mbox_sum = VECS[i].mb;
      perf_lines = VECS[i].pf; periph_line = VECS[i].pp;
      bus_read(slot(A_PEND, int'(VECS[i].core)), rd);
      chk("R5 pending word", rd, VECS[i].exp);
      chk("R6 irq is OR of pending", 32'(core_irq[VECS[i].core]), 32'(|VECS[i].exp));
    end

    // R3 R4: set and clear masks
    tmr_lines = '0; mbox_sum = '0; perf_lines = '0; periph_line = 1'b0;
    bus_write(A_CLR, 32'hF);
    bus_write(A_SET, 32'h5);
    bus_read(A_SET, rd);
    chk("R3 set mask", rd, 32'h5);
    bus_write(A_SET, 32'h2);
    bus_read(A_CLR, rd);
    chk("R3 zeros in set leave bits", rd, 32'h7);
    bus_write(A_CLR, 32'h4);
    bus_read(A_SET, rd);
    chk("R4 clear mask", rd, 32'h3);
    bus_write(A_CLR, 32'h0);
    bus_read(A_CLR, rd);
    chk("R4 zeros in clear leave bits", rd, 32'h3);

    // R7: level behaviour, no latching
    bus_write(A_CLR, 32'hF);
    bus_write(slot(A_TMR, 0), 32'h1);
    @(negedge clk);
    tmr_lines = 16'h0001;
    #1 chk("R7 irq follows source high", 32'(core_irq[0]), 32'h1);
    tmr_lines = 16'h0000;
    #1 chk("R7 irq drops without clock", 32'(core_irq[0]), 32'h0);
    bus_read(slot(A_PEND, 0), rd);
    chk("R7 pending not held", rd, 32'h0);

    // R8: inert writes and unmapped reads
    bus_write(A_SET, 32'h5);
    bus_write(slot(A_TMR, 1), 32'h6);
    bus_write(slot(A_PEND, 0), 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h45, 32'hFFFF_FFFF);
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_read(slot(A_TMR, 1), rd);
    chk("R8 enables untouched", rd, 32'h6);
    bus_read(A_SET, rd);
    chk("R8 routing untouched", rd, 32'h5);
    bus_read(8'h20, rd);
    chk("R8 unmapped read", rd, 32'h0);
    bus_read(8'h45, rd);
    chk("R8 misaligned read", rd, 32'h0);

    // R9: per-core isolation
    bus_write(slot(A_TMR, 2), 32'h9);
    bus_read(slot(A_TMR, 1), rd);
    chk("R9 core1 unchanged", rd, 32'h6);
    bus_read(slot(A_TMR, 3), rd);
    chk("R9 core3 unchanged", rd, 32'h8);
    bus_read(slot(A_TMR, 2), rd);
    chk("R9 core2 written", rd, 32'h9);

    // R2: only four enable bits stored
    bus_write(slot(A_TMR, 1), 32'hFFFF_FFFF);
    bus_read(slot(A_TMR, 1), rd);
    chk("R2 upper bits read zero", rd, 32'hF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule